// File: doc/BRIEF.md
# Free-Running Timestamp Counter with Tear-Free Capture

This block keeps a 56-bit timestamp that counts upward without stopping. Its tick comes from the system clock through a small prescaler. Software reaches the block through a synchronous register port. The count itself can only be read. A single control field sets the tick rate, and setting that field to zero stops the count.

The count is wider than one 32-bit data word, so a plain pair of reads could tear. This happens when the low half rolls over between reading the low half and reading the high half. To prevent this, any read of the low-word register also copies the upper 24 counter bits into a capture register in the same cycle. The copy comes from the same counter value that the low-word read returns. Software can read the capture register later and join the two halves into one consistent 56-bit value, and the counter never has to pause.

The request side is a valid strobe with no ready signal. The block accepts a request in every cycle in which `req_valid` is high, so it never applies back-pressure, and a requester may issue one request per cycle. The response side carries `rsp_valid`, which the requester cannot refuse. Each read produces exactly one response beat, one cycle after the request. Writes produce no response.

Top module: `stamp_timer`

## Requirements
- R1: The counter is 56 bits wide and counts upward. After the all-ones value it wraps to zero.
- R2: After reset the rate field holds 001 and the capture register holds zero. The counter starts at its preload parameter value and advances on every clock edge after reset is released, with no enable from software.
- R3: The rate field sits in bits 10:8 of the control register at byte offset 0x0. A value n from 1 to 7 advances the counter once every n clock cycles. The value 000 stops the counter.
- R4: A write to the control register restarts the prescaler. After writing rate n, the counter's next advance comes n cycles after the write is accepted.
- R5: A read at offset 0x4 returns counter bits 31:0. In the same cycle, counter bits 55:32 of that same counter value are copied into the capture register.
- R6: A read at offset 0x8 returns the captured upper 24 bits, zero-extended to 32 bits. The captured value does not change until the next read at offset 0x4, even while the counter moves on.
- R7: Writes to offset 0x4 or 0x8 have no effect on the count or on the capture register.
- R8: The control register bits other than 10:8 read as zero, and writes to them are ignored.
- R9: A read of any other address returns zero. This includes offsets 0xC and above, and any address whose two low bits are not zero.
- R10: Every read request produces `rsp_valid` high for exactly one cycle, on the cycle after the request, with registered data. Write requests and idle cycles produce no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe; always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid, one cycle after a read |
| rsp_rdata | output | 32 | Read response data |

## Verification
The bench preloads one instance of the counter just below a carry into bit 32. It then reads the low word, waits many cycles past the carry, and reads the capture register. A design that captured late, or that captured from the post-increment value, would return a value whose upper part is one too high. A second instance is preloaded near all-ones to show the wrap to zero; a design with a narrower count or a saturating count would not return to zero. Rate changes are followed by reads on every cycle. These show that the first advance after a control write comes a full period later, and that rate zero freezes the count. A prescaler that kept its old phase, or that counted one extra cycle, would drift from the reference model on the very first read. Writes to the read-only offsets and to unused control bits are each followed by reads that would show any stray change.

// File: rtl/stamp_timer_pkg.sv
package stamp_timer_pkg;

  // Register select derived from the word index of a request address.
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_LOW  = 2'd1,
    SEL_CAP  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Bit position of the rate field inside the control register.
  localparam int RATE_LSB = 8;

  // Rate field value loaded at reset.
  localparam int RATE_RESET = 1;

endpackage

// File: rtl/stamp_prescaler.sv
module stamp_prescaler #(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              restart_i,
  output logic              tick_o
);

  localparam logic [RATE_W-1:0] ONE = RATE_W'(1);

  logic [RATE_W-1:0] phase_q;
  logic              running;

  assign running = (rate_i != '0);
  assign tick_o  = running && (phase_q == rate_i - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart_i || tick_o) begin
      phase_q <= '0;
    end else if (running) begin
      phase_q <= phase_q + ONE;
    end
  end

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && rate_i > ONE && !restart_i) |=> !tick_o);

  // R3
  stopped_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_i == '0 && !restart_i) |=> (!tick_o || rate_i != '0));

endmodule

// File: rtl/stamp_counter.sv
module stamp_counter #(
  parameter int          CNT_W = 56,
  parameter logic [55:0] INIT  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(INIT);
    end else if (tick_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));

  // R1
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && (&cnt_q)) |=> (cnt_q == '0));

endmodule

// File: rtl/stamp_regfile.sv
module stamp_regfile
  import stamp_timer_pkg::*;
#(
  parameter int CNT_W  = 56,
  parameter int LO_W   = 32,
  parameter int RATE_W = 3,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LO_W-1:0]   req_wdata,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [RATE_W-1:0] rate_o,
  output logic              restart_o,
  output logic              rsp_valid,
  output logic [LO_W-1:0]   rsp_rdata
);

  localparam int HI_W = CNT_W - LO_W;

  reg_sel_e          sel;
  logic              rd_req, wr_req, low_rd;
  logic [RATE_W-1:0] rate_q;
  logic [HI_W-1:0]   cap_q;
  logic [LO_W-1:0]   rd_mux;
  logic              unused_wdata;

  always_comb begin
    sel = SEL_NONE;
    if (req_addr[1:0] == 2'b00) begin
      case (req_addr[ADDR_W-1:2])
        (ADDR_W-2)'(0): sel = SEL_CTRL;
        (ADDR_W-2)'(1): sel = SEL_LOW;
        (ADDR_W-2)'(2): sel = SEL_CAP;
        default:        sel = SEL_NONE;
      endcase
    end
  end

  assign rd_req    = req_valid && !req_write;
  assign wr_req    = req_valid && req_write;
  assign low_rd    = rd_req && (sel == SEL_LOW);
  assign restart_o = wr_req && (sel == SEL_CTRL);
  assign rate_o    = rate_q;
  assign unused_wdata = ^req_wdata;

  always_comb begin
    case (sel)
      SEL_CTRL: rd_mux = LO_W'(rate_q) << RATE_LSB;
      SEL_LOW:  rd_mux = cnt_i[LO_W-1:0];
      SEL_CAP:  rd_mux = LO_W'(cap_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= RATE_W'(RATE_RESET);
    end else if (restart_o) begin
      rate_q <= req_wdata[RATE_LSB +: RATE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (low_rd) begin
      cap_q <= cnt_i[CNT_W-1:LO_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) begin
        rsp_rdata <= rd_mux;
      end
    end
  end

  // R10
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);

  // R10
  no_rsp_without_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid);

  // R5
  low_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_rd |=> (cap_q == $past(cnt_i[CNT_W-1:LO_W])) &&
               (rsp_rdata == $past(cnt_i[LO_W-1:0])));

  // R6
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !low_rd |=> $stable(cap_q));

endmodule

// File: rtl/stamp_timer.sv
module stamp_timer #(
  parameter int          CNT_W  = 56,
  parameter int          LO_W   = 32,
  parameter int          RATE_W = 3,
  parameter int          ADDR_W = 5,
  parameter logic [55:0] INIT   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LO_W-1:0]   req_wdata,
  output logic              rsp_valid,
  output logic [LO_W-1:0]   rsp_rdata
);

  logic [RATE_W-1:0] rate;
  logic              restart;
  logic              tick;
  logic [CNT_W-1:0]  cnt;

  stamp_prescaler #(.RATE_W(RATE_W)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_i    (rate),
    .restart_i (restart),
    .tick_o    (tick)
  );

  stamp_counter #(.CNT_W(CNT_W), .INIT(INIT)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick),
    .cnt_o  (cnt)
  );

  stamp_regfile #(
    .CNT_W  (CNT_W),
    .LO_W   (LO_W),
    .RATE_W (RATE_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .cnt_i     (cnt),
    .rate_o    (rate),
    .restart_o (restart),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  // R7
  bus_write_no_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));

endmodule

// File: tb/tb_stamp_timer.sv
module tb_stamp_timer;

  localparam logic [55:0] INIT_A = 56'hAB_CDEF_FFFF_FFC0;
  localparam logic [55:0] INIT_B = 56'hFF_FFFF_FFFF_FFE0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_valid_b;
  logic [31:0] rsp_rdata, rsp_rdata_b;

  always #5 clk = ~clk;

  stamp_timer #(.INIT(INIT_A)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

  stamp_timer #(.INIT(INIT_B)) dut_wrap (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid_b), .rsp_rdata(rsp_rdata_b));

  int checks = 0;
  int fails  = 0;
  string phase_tag = "R2";

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, updated on every clock edge.
  logic [55:0] m_cnt_a, m_cnt_b, m_snap;
  logic [23:0] m_cap_a, m_cap_b;
  int          m_rate, m_phase;
  logic        e_valid;
  logic [31:0] e_data_a, e_data_b;
  string       e_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt_a <= INIT_A; m_cnt_b <= INIT_B; m_snap <= '0;
      m_cap_a <= '0; m_cap_b <= '0;
      m_rate <= 1; m_phase <= 0;
      e_valid <= 1'b0; e_data_a <= '0; e_data_b <= '0; e_tag <= "R2";
    end else begin
      int idx;
      bit tick;
      idx = (req_addr[1:0] == 2'b00) ? int'(req_addr[4:2]) : 99;
      tick = (m_rate != 0) && (m_phase == m_rate - 1);
      e_valid <= req_valid && !req_write;
      if (req_valid && !req_write) begin
        e_tag <= phase_tag;
        if (idx == 0) begin
          e_data_a <= 32'(m_rate) * 256; e_data_b <= 32'(m_rate) * 256;
        end else if (idx == 1) begin
          e_data_a <= m_cnt_a[31:0]; e_data_b <= m_cnt_b[31:0];
          m_cap_a <= m_cnt_a[55:32]; m_cap_b <= m_cnt_b[55:32];
          m_snap <= m_cnt_a;
        end else if (idx == 2) begin
          e_data_a <= {8'h00, m_cap_a}; e_data_b <= {8'h00, m_cap_b};
        end else begin
          e_data_a <= '0; e_data_b <= '0;
        end
      end
      if (tick) begin
        m_cnt_a <= m_cnt_a + 56'd1;
        m_cnt_b <= m_cnt_b + 56'd1;
      end
      if (req_valid && req_write && idx == 0) begin
        m_rate <= int'(req_wdata[10:8]);
        m_phase <= 0;
      end else if (tick) begin
        m_phase <= 0;
      end else if (m_rate != 0) begin
        m_phase <= m_phase + 1;
      end
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      check("R10 valid", {63'd0, rsp_valid}, {63'd0, e_valid});
      check("R10 valid(wrap inst)", {63'd0, rsp_valid_b}, {63'd0, e_valid});
      if (e_valid) begin
        check({e_tag, " data"}, {32'd0, rsp_rdata}, {32'd0, e_data_a});
        check({e_tag, " data(wrap inst, R1)"}, {32'd0, rsp_rdata_b}, {32'd0, e_data_b});
      end
    end else begin
      check("R2 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
    end
  end

  task automatic issue(bit wr, logic [4:0] a, logic [31:0] d);
    @(posedge clk); #2;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
  endtask

  task automatic idle(int n);
    @(posedge clk); #2;
    req_valid = 1'b0; req_write = 1'b0;
    for (int i = 1; i < n; i++) @(posedge clk);
  endtask

  task automatic rd_get(logic [4:0] a, output logic [31:0] d);
    issue(1'b0, a, '0);
    @(posedge clk); #2;
    req_valid = 1'b0;
    @(negedge clk);
    d = rsp_rdata;
  endtask

  bit done = 1'b0;
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 50000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lo, hi, v;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R2: reset values of control and capture
    phase_tag = "R2";
    rd_get(5'h00, v); check("R2 ctrl reset", {32'd0, v}, 64'h100);
    rd_get(5'h08, v); check("R2 cap reset", {32'd0, v}, 64'd0);
    issue(1'b0, 5'h04, '0); issue(1'b0, 5'h04, '0); idle(2);

    // R8: only bits 10:8 are writable
    phase_tag = "R8";
    issue(1'b1, 5'h00, 32'hFFFF_F9FF); idle(1);
    rd_get(5'h00, v); check("R8 ctrl readback", {32'd0, v}, 64'h100);

    // R5/R6: low read just before the carry into bit 32, capture read later
    phase_tag = "R5";
    while (m_cnt_a[31:0] < 32'hFFFF_FFF8) @(posedge clk);
    rd_get(5'h04, lo);
    idle(30);
    phase_tag = "R6";
    rd_get(5'h08, hi);
    check("R5 tear-free 56-bit join", {8'd0, hi[23:0], lo}, {8'd0, m_snap});
    check("R6 carry crossed between reads", {63'd0, m_cnt_a[55:32] != hi[23:0]}, 64'd1);
    rd_get(5'h08, v); check("R6 capture held", {32'd0, v}, {32'd0, hi});

    // R1: wrap instance has passed all-ones by now
    phase_tag = "R1";
    for (int i = 0; i < 4; i++) issue(1'b0, 5'h04, '0);
    idle(2);

    // R7: writes to read-only offsets
    phase_tag = "R7";
    issue(1'b1, 5'h04, 32'h0); issue(1'b1, 5'h08, 32'hFFFF_FFFF);
    issue(1'b0, 5'h08, '0); issue(1'b0, 5'h04, '0); issue(1'b0, 5'h08, '0); idle(2);

    // R3: slow rates and stop
    phase_tag = "R3";
    issue(1'b1, 5'h00, 32'h300);
    for (int i = 0; i < 9; i++) issue(1'b0, 5'h04, '0);
    issue(1'b1, 5'h00, 32'h000); idle(6);
    issue(1'b0, 5'h04, '0); idle(4);
    rd_get(5'h04, v); check("R3 stopped count", {32'd0, v}, {32'd0, m_cnt_a[31:0]});
    issue(1'b1, 5'h00, 32'h700);
    for (int i = 0; i < 16; i++) issue(1'b0, 5'h04, '0);
    idle(2);

    // R4: write restarts prescaler mid-period
    phase_tag = "R4";
    issue(1'b1, 5'h00, 32'h500); issue(1'b0, 5'h04, '0); issue(1'b0, 5'h04, '0);
    issue(1'b1, 5'h00, 32'h500);
    for (int i = 0; i < 12; i++) issue(1'b0, 5'h04, '0);
    issue(1'b1, 5'h00, 32'h100); idle(2);

    // R9: unmapped and misaligned addresses
    phase_tag = "R9";
    issue(1'b0, 5'h0C, '0); issue(1'b0, 5'h1C, '0); issue(1'b0, 5'h05, '0);
    issue(1'b0, 5'h10, '0); idle(2);

    // R10: mixed traffic, writes give no response
    phase_tag = "R10";
    issue(1'b0, 5'h04, '0); issue(1'b1, 5'h0C, 32'h1); issue(1'b0, 5'h08, '0);
    issue(1'b1, 5'h00, 32'h200); issue(1'b0, 5'h00, '0); idle(5);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule